// File: doc/BRIEF.md
# DMA Channel Event Status and Interrupt Control

This block is the register-side companion of an eight-channel DMA controller. It keeps, for every channel, an enable bit and three interrupt mask bits. It gathers the completion, abort and error events that the transfer engines report into one status word whose bits software clears by writing ones. It accepts per-channel abort requests and a global software reset. It drives a single interrupt line and an idle indication.

Software uses a flat word-addressed write port. Reads are combinational on the same address. The transfer engines deliver one-cycle `done_i` and `err_i` pulses. In return they receive each channel's enable level and a one-cycle abort strobe. A one-cycle core reset strobe accompanies a software reset.

Register offsets (byte addresses): 0x00 identification (idle flag), 0x04 global control (write only), 0x08 abort request (write only), 0x0C event status, 0x10 enable mirror (read only), 0x20 + 4·n control of channel n.

Top module: `dmac_evt_regs`

## Requirements
- R1: After reset, status, the enable mirror and every channel control register read 0, `irq_o` is 0 and `idle_o` is 1. Status at 0x0C places the terminal-count flags of channels 7..0 in bits 23:16, the abort flags in bits 15:8 and the error flags in bits 7:0. All other bits read 0.
- R2: Writing the status word clears each flag whose bit is written as 1. Bits written as 0 keep their value.
- R3: A `done_i` pulse on an enabled channel sets its terminal-count flag only when the same cycle has no `err_i` and no accepted abort for that channel. An `err_i` pulse on an enabled channel sets its error flag. Pulses on a disabled channel change nothing.
- R4: Writing 1 to bit n of 0x08 while channel n is enabled raises `abort_req_o[n]` in that write cycle, sets abort flag n and clears the enable of channel n. For a disabled channel the write has no effect on any output or register.
- R5: Writing 1 to bit 0 of 0x04 raises `core_rst_o` in that cycle and clears every channel's enable. Mask bits and status flags are kept.
- R6: The enable mirror at 0x10 holds, and `ch_en_o` drives, the enable of channel n at bit n.
- R7: Channel control at 0x20 + 4·n has enable at bit 0, abort mask at bit 1, error mask at bit 2 and terminal-count mask at bit 3. It reads back as written. Its enable clears itself when the channel completes, errors or is aborted, even if a write in the same cycle sets it.
- R8: Bit 15 of 0x00, and `idle_o`, read 1 when no channel is enabled and 0 otherwise.
- R9: `irq_o` is 1 exactly when some status flag is 1 while its mask bit is 0. Mask bits never affect the status flags.
- R10: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| done_i | input | 8 | Per-channel completion pulse |
| err_i | input | 8 | Per-channel error pulse |
| ch_en_o | output | 8 | Per-channel enable level |
| abort_req_o | output | 8 | Per-channel abort strobe |
| core_rst_o | output | 1 | Software reset strobe |
| idle_o | output | 1 | No channel enabled |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: eight channels and a six-bit address. With these values each status group fills a full byte lane. Channel 7's control register then sits at the very top of the address space, so the lane boundaries and the last control slot are both exercised. The directed scenarios cover the priority corners: done together with error, an abort write that mixes enabled and disabled channels, an event colliding with a clearing write, and a software reset racing with masked channels. The bench also unmasks a pending flag and checks that the interrupt rises.

// File: rtl/dmac_evt_pkg.sv
package dmac_evt_pkg;

    localparam int REG_W = 32;

    // byte offsets of the shared registers
    localparam int OFS_IDENT   = 'h00;
    localparam int OFS_GCTRL   = 'h04;
    localparam int OFS_ABORT   = 'h08;
    localparam int OFS_STATUS  = 'h0C;
    localparam int OFS_ENMIR   = 'h10;
    localparam int OFS_CHBASE  = 'h20;

    // field positions the software relies on
    localparam int IDLE_BIT    = 15;
    localparam int SRST_BIT    = 0;
    localparam int STAT_TC_LSB = 16;
    localparam int STAT_AB_LSB = 8;
    localparam int STAT_ER_LSB = 0;

    // per-channel control word, enable in the LSB
    typedef struct packed {
        logic tc_msk;
        logic err_msk;
        logic abt_msk;
        logic en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // three event classes held per channel
    typedef struct packed {
        logic tc;
        logic abt;
        logic err;
    } evt_t;

    function automatic logic evt_pending(input evt_t s, input ctrl_t c);
        return (s.tc & ~c.tc_msk) | (s.abt & ~c.abt_msk) | (s.err & ~c.err_msk);
    endfunction

endpackage

// File: rtl/dmac_reg_dec.sv
module dmac_reg_dec
    import dmac_evt_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 6
) (
    input  logic          we,
    input  logic [AW-1:0] addr,
    output logic          gctrl_we,
    output logic          abort_we,
    output logic          stat_we,
    output logic [NCH-1:0] ctrl_we,
    output logic [NCH-1:0] ctrl_rsel
);

    always_comb begin
        gctrl_we = we && (addr == AW'(OFS_GCTRL));
        abort_we = we && (addr == AW'(OFS_ABORT));
        stat_we  = we && (addr == AW'(OFS_STATUS));
    end

    for (genvar n = 0; n < NCH; n++) begin : g_sel
        assign ctrl_rsel[n] = (addr == AW'(OFS_CHBASE + 4 * n));
        assign ctrl_we[n]   = we && ctrl_rsel[n];
    end

endmodule

// File: rtl/dmac_chan_slice.sv
module dmac_chan_slice
    import dmac_evt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ctrl_we,
    input  ctrl_t ctrl_wr,
    input  logic  abort_wr,
    input  logic  sreset,
    input  evt_t  clr,
    input  logic  done_i,
    input  logic  err_i,
    output ctrl_t ctrl_o,
    output evt_t  stat_o,
    output logic  abort_o,
    output logic  irq_o
);

    ctrl_t ctrl_q;
    evt_t  stat_q;
    logic  abort_ok, err_ev, fin_ev, tc_ev, stop;

    always_comb begin
        abort_ok = abort_wr & ctrl_q.en;
        err_ev   = err_i & ctrl_q.en;
        fin_ev   = done_i & ctrl_q.en;
        tc_ev    = fin_ev & ~err_ev & ~abort_ok;
        stop     = abort_ok | err_ev | fin_ev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            if (ctrl_we)
                ctrl_q <= ctrl_wr;
            if (sreset || stop)
                ctrl_q.en <= 1'b0;
            stat_q.tc  <= (stat_q.tc  & ~clr.tc)  | tc_ev;
            stat_q.abt <= (stat_q.abt & ~clr.abt) | abort_ok;
            stat_q.err <= (stat_q.err & ~clr.err) | err_ev;
        end
    end

    assign ctrl_o  = ctrl_q;
    assign stat_o  = stat_q;
    assign abort_o = abort_ok;
    assign irq_o   = evt_pending(stat_q, ctrl_q);

    // R4: abort write to a disabled channel leaves a clear abort flag clear
    p_abort_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (abort_wr && !ctrl_q.en && !stat_q.abt) |=> !stat_q.abt);

    // R3: done with a simultaneous error or abort never yields terminal count
    p_tc_clean_r3: assert property (@(posedge clk) disable iff (rst)
        (done_i && (err_i || abort_wr) && !stat_q.tc) |=> !stat_q.tc);

    // R5: software reset disables the channel
    p_sreset_off_r5: assert property (@(posedge clk) disable iff (rst)
        sreset |=> !ctrl_q.en);

    // R10: event beats a clearing write on the error flag
    p_evt_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (err_i && ctrl_q.en && clr.err) |=> stat_q.err);

    // R2: a clear with no competing event empties the error flag
    p_w1c_err_r2: assert property (@(posedge clk) disable iff (rst)
        (clr.err && !(err_i && ctrl_q.en)) |=> !stat_q.err);

endmodule

// File: rtl/dmac_evt_regs.sv
module dmac_evt_regs
    import dmac_evt_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [NCH-1:0]   done_i,
    input  logic [NCH-1:0]   err_i,
    output logic [NCH-1:0]   ch_en_o,
    output logic [NCH-1:0]   abort_req_o,
    output logic             core_rst_o,
    output logic             idle_o,
    output logic             irq_o
);

    localparam int LANE = STAT_AB_LSB - STAT_ER_LSB;

    logic           gctrl_we, abort_we, stat_we, sreset;
    logic [NCH-1:0] ctrl_we, ctrl_rsel, irq_ch;
    ctrl_t          ctrl_q [NCH];
    evt_t           stat_q [NCH];
    logic [REG_W-1:0] stat_word, enmir_word;
    logic           unused_wdata;

    assign unused_wdata = ^reg_wdata;

    dmac_reg_dec #(.NCH(NCH), .AW(AW)) u_dec (
        .we       (reg_we),
        .addr     (reg_addr),
        .gctrl_we (gctrl_we),
        .abort_we (abort_we),
        .stat_we  (stat_we),
        .ctrl_we  (ctrl_we),
        .ctrl_rsel(ctrl_rsel)
    );

    assign sreset = gctrl_we && reg_wdata[SRST_BIT];

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        evt_t clr_n;
        assign clr_n.tc  = stat_we && reg_wdata[STAT_TC_LSB + n];
        assign clr_n.abt = stat_we && reg_wdata[STAT_AB_LSB + n];
        assign clr_n.err = stat_we && reg_wdata[STAT_ER_LSB + n];

        dmac_chan_slice u_ch (
            .clk     (clk),
            .rst     (rst),
            .ctrl_we (ctrl_we[n]),
            .ctrl_wr (ctrl_t'(reg_wdata[CTRL_W-1:0])),
            .abort_wr(abort_we && reg_wdata[n]),
            .sreset  (sreset),
            .clr     (clr_n),
            .done_i  (done_i[n]),
            .err_i   (err_i[n]),
            .ctrl_o  (ctrl_q[n]),
            .stat_o  (stat_q[n]),
            .abort_o (abort_req_o[n]),
            .irq_o   (irq_ch[n])
        );

        assign ch_en_o[n] = ctrl_q[n].en;
    end

    always_comb begin
        stat_word  = '0;
        enmir_word = '0;
        for (int n = 0; n < NCH && n < LANE; n++) begin
            stat_word[STAT_TC_LSB + n] = stat_q[n].tc;
            stat_word[STAT_AB_LSB + n] = stat_q[n].abt;
            stat_word[STAT_ER_LSB + n] = stat_q[n].err;
            enmir_word[n]              = ctrl_q[n].en;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(OFS_IDENT):  reg_rdata[IDLE_BIT] = idle_o;
            AW'(OFS_STATUS): reg_rdata = stat_word;
            AW'(OFS_ENMIR):  reg_rdata = enmir_word;
            default: begin
                for (int n = 0; n < NCH; n++)
                    if (ctrl_rsel[n])
                        reg_rdata[CTRL_W-1:0] = ctrl_q[n];
            end
        endcase
    end

    assign core_rst_o = sreset;
    assign idle_o     = (ch_en_o == '0);
    assign irq_o      = |irq_ch;

    // R5: after a software reset every channel is disabled and the block idles
    p_sreset_idle_r5: assert property (@(posedge clk) disable iff (rst)
        core_rst_o |=> idle_o);

    // R4: an abort strobe is only issued to an enabled channel
    p_abort_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (abort_req_o & ~ch_en_o) == '0);

    // R8: an idle block has no channel issuing abort strobes
    p_idle_no_abort_r8: assert property (@(posedge clk) disable iff (rst)
        idle_o |-> (abort_req_o == '0));

endmodule

// File: tb/sim_dmac_evt_regs.sv
module sim_dmac_evt_regs;
    import dmac_evt_pkg::*;

    localparam int NCH = 8;
    localparam int AW  = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_we = 1'b0;
    logic [AW-1:0]    reg_addr = '0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic [NCH-1:0]   done_i = '0;
    logic [NCH-1:0]   err_i = '0;
    logic [NCH-1:0]   ch_en_o, abort_req_o;
    logic             core_rst_o, idle_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dmac_evt_regs #(.NCH(NCH), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_i(done_i),
        .err_i(err_i), .ch_en_o(ch_en_o), .abort_req_o(abort_req_o),
        .core_rst_o(core_rst_o), .idle_o(idle_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = AW'(a);
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [NCH-1:0] dn, input logic [NCH-1:0] er);
        @(negedge clk);
        done_i = dn; err_i = er;
        @(negedge clk);
        done_i = '0; err_i = '0;
    endtask

    function automatic int chofs(input int n);
        return OFS_CHBASE + 4 * n;
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(OFS_STATUS, v); chk("R1 status after reset", v, 0);
        rd(OFS_ENMIR, v);  chk("R1 enable mirror after reset", v, 0);
        rd(chofs(7), v);   chk("R1 ch7 ctrl after reset", v, 0);
        rd(OFS_IDENT, v);  chk("R8 idle flag after reset", v, 32'h8000);
        chk("R1 irq after reset", {31'b0, irq_o}, 0);
    endtask

    task automatic t_enable_done();
        logic [31:0] v;
        wr(chofs(2), 1);
        rd(OFS_ENMIR, v);  chk("R6 mirror ch2", v, 32'h04);
        chk("R6 ch_en_o", {24'b0, ch_en_o}, 32'h04);
        rd(chofs(2), v);   chk("R7 ctrl readback", v, 1);
        rd(OFS_IDENT, v);  chk("R8 busy", v, 0);
        pulse(8'h04, 8'h00);
        rd(OFS_STATUS, v); chk("R3 tc ch2 at bit 18", v, 32'h0004_0000);
        rd(OFS_ENMIR, v);  chk("R7 enable self-clears", v, 0);
        chk("R9 irq on unmasked tc", {31'b0, irq_o}, 1);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(OFS_STATUS, 32'h0000_FFFF);
        rd(OFS_STATUS, v); chk("R2 zero bits keep flag", v, 32'h0004_0000);
        wr(OFS_STATUS, 32'h0004_0000);
        rd(OFS_STATUS, v); chk("R2 one clears flag", v, 0);
        chk("R9 irq drops", {31'b0, irq_o}, 0);
    endtask

    task automatic t_err_done();
        logic [31:0] v;
        wr(chofs(3), 1);
        pulse(8'h08, 8'h08);
        rd(OFS_STATUS, v); chk("R3 error beats done", v, 32'h0000_0008);
        wr(OFS_STATUS, 32'h0000_0008);
        pulse(8'h20, 8'h20);
        rd(OFS_STATUS, v); chk("R3 disabled ch5 events ignored", v, 0);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        wr(chofs(1), 1);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(OFS_ABORT); reg_wdata = 32'h22;
        #1 chk("R4 abort strobe only ch1", {24'b0, abort_req_o}, 32'h02);
        @(negedge clk);
        reg_we = 1'b0;
        rd(OFS_STATUS, v); chk("R4 abort flag ch1 bit 9", v, 32'h0000_0200);
        rd(OFS_ENMIR, v);  chk("R4 ch1 disabled", v, 0);
        wr(OFS_STATUS, 32'h0000_0200);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(chofs(4), 32'h9);
        pulse(8'h10, 8'h00);
        rd(OFS_STATUS, v); chk("R9 mask keeps status", v, 32'h0010_0000);
        chk("R9 masked irq low", {31'b0, irq_o}, 0);
        wr(chofs(4), 0);
        #1 chk("R9 unmask raises irq", {31'b0, irq_o}, 1);
        wr(OFS_STATUS, 32'h0010_0000);
    endtask

    task automatic t_race();
        logic [31:0] v;
        wr(chofs(0), 1);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(OFS_STATUS); reg_wdata = 32'h1; err_i = 8'h01;
        @(negedge clk);
        reg_we = 1'b0; err_i = '0;
        rd(OFS_STATUS, v); chk("R10 event wins over clear", v, 32'h1);
        wr(OFS_STATUS, 32'h1);
    endtask

    task automatic t_sreset();
        logic [31:0] v;
        wr(chofs(6), 1);
        wr(chofs(7), 32'hF);
        rd(OFS_ENMIR, v); chk("R6 ch6 ch7 on", v, 32'hC0);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(OFS_GCTRL); reg_wdata = 32'h1;
        #1 chk("R5 core reset strobe", {31'b0, core_rst_o}, 1);
        @(negedge clk);
        reg_we = 1'b0;
        rd(OFS_ENMIR, v); chk("R5 all disabled", v, 0);
        rd(chofs(7), v);  chk("R5 masks kept", v, 32'hE);
        chk("R8 idle output", {31'b0, idle_o}, 1);
        rd(OFS_STATUS, v); chk("R5 status untouched", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable_done();
        t_w1c();
        t_err_done();
        t_abort();
        t_mask();
        t_race();
        t_sreset();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule